// File: doc/BRIEF.md
# Asynchronous Interrupt Priority Controller

This block keeps track of the asynchronous interrupt sources of a processor core and picks which one to deliver. It has three candidates. The first is a floating-point enabled exception, raised from the floating-point exception-mode bits and the floating-point summary-enable status bit. The second is an external interrupt line, which is level-sensitive. The third is a decrementer expiry, which arrives as a one-cycle pulse.

When a delivery is allowed, the block issues a single-cycle take request to the exception entry unit. The request carries a vector offset and the cause bits for the saved status register. The block then waits for a take acknowledge before it raises another request.

The two timer-style sources are held pending in different ways:

- The external flag mirrors the input line. It stays pending through a delivery and drops only when the line falls.
- The decrementer flag is sticky. It is consumed by the delivery that serves it.

Both of these sources are gated by the external-enable bit. The floating-point enabled exception is checked first and ignores that bit. A source that was masked while pending is delivered as soon as the enable conditions are met.

Top module: `irq_arbiter`

## Requirements
- R1: Reset clears the external and decrementer pending flags and any outstanding request. A decrementer event taken before reset is not delivered after reset even when enabled.
- R2: When any floating-point exception-mode bit is 1 and the summary-enable bit is 1, a request is issued one clock edge later.
  - The request uses vector 0x700.
  - Its cause value is 0x0012_0000: bit 20 is floating-point enabled and bit 17 is subsequent instruction.
  - This happens whatever the external-enable bit is.
  - With every mode bit 0, the summary-enable bit raises nothing.
- R3: External and decrementer sources raise no request while the external-enable input is 0.
- R4: When the external and decrementer flags are both pending and enabled, the external source is served first.
- R5: The external pending flag follows the line with one register of delay.
  - It is not cleared by a delivery, so after the acknowledge the source is requested again while the line stays high and enable is 1.
  - A line that falls while masked leaves nothing to deliver.
- R6: A decrementer pulse sets a sticky flag that is delivered with vector 0x900 and cause 0. Issuing that request clears the flag, so it is delivered once.
- R7: A source that is pending while masked is requested one clock edge after the external-enable input becomes 1. The external source uses vector 0x500 and cause 0.
- R8: The take request is high for exactly one cycle per delivery. After a request, no further request is issued until the acknowledge input has been 1 at a clock edge. An acknowledge while no request is outstanding is ignored.
- R9: A decrementer pulse in the same cycle as the issue of a decrementer request leaves the flag set, so a second decrementer request follows after the acknowledge.
- R10: While the take request is 0, the vector and cause outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 1 | External interrupt line, level-sensitive |
| dec_pulse_i | input | 1 | Decrementer expiry, one-cycle pulse |
| ext_en_i | input | 1 | External-enable bit from the machine state register |
| fp_mode_i | input | FP_MODE_W (2) | Floating-point exception-mode bits |
| fp_sum_i | input | 1 | Floating-point summary-enable status bit |
| take_ack_i | input | 1 | Acknowledge from the exception entry unit |
| take_req_o | output | 1 | One-cycle take request |
| take_vec_o | output | VEC_W (12) | Vector offset of the request |
| take_cause_o | output | CAUSE_W (32) | Cause bits for the saved status register |

## Verification
A floating-point request appears one edge after its inputs are applied, because the inputs feed the decision directly. An external or decrementer request appears two edges after the line or pulse, because the pending flag adds one register. After an edge that carries an acknowledge, the next request can appear at the following edge at the earliest.

The bench drives inputs 1 ns after a rising edge and samples outputs 1 ns after the next edge. Each directed check is placed at the edge counted from these latencies. The random phase advances a reference model once per edge and compares the request, vector and cause on every cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FPE  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_DEC  = 2'd3
    } src_e;

    localparam int unsigned VEC_FPE_OFS = 32'h700;
    localparam int unsigned VEC_EXT_OFS = 32'h500;
    localparam int unsigned VEC_DEC_OFS = 32'h900;

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int unsigned FP_MODE_W = 2
) (
    input  logic [FP_MODE_W-1:0] fp_mode,
    input  logic                 fp_sum,
    input  logic                 ext_en,
    input  logic                 ext_pend,
    input  logic                 dec_pend,
    output src_e                 src
);
    logic fp_hit;

    assign fp_hit = (|fp_mode) && fp_sum;

    always_comb begin
        if (fp_hit) begin
            src = SRC_FPE;
        end else if (ext_en && ext_pend) begin
            src = SRC_EXT;
        end else if (ext_en && dec_pend) begin
            src = SRC_DEC;
        end else begin
            src = SRC_NONE;
        end
    end
endmodule

// File: rtl/irq_pend_next.sv
module irq_pend_next (
    input  logic ext_lvl,
    input  logic dec_pulse,
    input  logic dec_pend_q,
    input  logic dec_taken,
    output logic ext_pend_d,
    output logic dec_pend_d
);
    // The external flag mirrors the line; the decrementer flag is sticky,
    // and a fresh pulse wins over the clear caused by its own delivery.
    always_comb begin
        ext_pend_d = ext_lvl;
        dec_pend_d = dec_pulse || (dec_pend_q && !dec_taken);
    end
endmodule

// File: rtl/irq_encode.sv
module irq_encode
    import irq_arb_pkg::*;
#(
    parameter int unsigned VEC_W     = 12,
    parameter int unsigned CAUSE_W   = 32,
    parameter int unsigned FPE_BIT   = 20,
    parameter int unsigned NEXT_BIT  = 17
) (
    input  src_e               src,
    output logic [VEC_W-1:0]   vec,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] fpe_cause;

    for (genvar b = 0; b < CAUSE_W; b++) begin : g_cause
        assign fpe_cause[b] = (b == FPE_BIT) || (b == NEXT_BIT);
    end

    always_comb begin
        vec   = '0;
        cause = '0;
        unique case (src)
            SRC_FPE: begin
                vec   = VEC_W'(VEC_FPE_OFS);
                cause = fpe_cause;
            end
            SRC_EXT: vec = VEC_W'(VEC_EXT_OFS);
            SRC_DEC: vec = VEC_W'(VEC_DEC_OFS);
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned FP_MODE_W = 2,
    parameter int unsigned VEC_W     = 12,
    parameter int unsigned CAUSE_W   = 32,
    parameter int unsigned FPE_BIT   = 20,
    parameter int unsigned NEXT_BIT  = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_irq_i,
    input  logic                 dec_pulse_i,
    input  logic                 ext_en_i,
    input  logic [FP_MODE_W-1:0] fp_mode_i,
    input  logic                 fp_sum_i,
    input  logic                 take_ack_i,
    output logic                 take_req_o,
    output logic [VEC_W-1:0]     take_vec_o,
    output logic [CAUSE_W-1:0]   take_cause_o
);
    typedef struct packed {
        logic               ext_pend;
        logic               dec_pend;
        logic               busy;
        logic               req;
        logic [VEC_W-1:0]   vec;
        logic [CAUSE_W-1:0] cause;
    } arb_state_t;

    arb_state_t st_d, st_q;

    src_e               src;
    logic               issue;
    logic               dec_taken;
    logic               ext_pend_nx;
    logic               dec_pend_nx;
    logic [VEC_W-1:0]   enc_vec;
    logic [CAUSE_W-1:0] enc_cause;

    irq_pick #(.FP_MODE_W(FP_MODE_W)) u_pick (
        .fp_mode  (fp_mode_i),
        .fp_sum   (fp_sum_i),
        .ext_en   (ext_en_i),
        .ext_pend (st_q.ext_pend),
        .dec_pend (st_q.dec_pend),
        .src      (src)
    );

    irq_encode #(
        .VEC_W    (VEC_W),
        .CAUSE_W  (CAUSE_W),
        .FPE_BIT  (FPE_BIT),
        .NEXT_BIT (NEXT_BIT)
    ) u_enc (
        .src   (src),
        .vec   (enc_vec),
        .cause (enc_cause)
    );

    irq_pend_next u_pend (
        .ext_lvl    (ext_irq_i),
        .dec_pulse  (dec_pulse_i),
        .dec_pend_q (st_q.dec_pend),
        .dec_taken  (dec_taken),
        .ext_pend_d (ext_pend_nx),
        .dec_pend_d (dec_pend_nx)
    );

    always_comb begin
        issue     = !st_q.busy && (src != SRC_NONE);
        dec_taken = issue && (src == SRC_DEC);

        st_d          = st_q;
        st_d.ext_pend = ext_pend_nx;
        st_d.dec_pend = dec_pend_nx;
        st_d.busy     = st_q.busy ? !take_ack_i : issue;
        st_d.req      = issue;
        st_d.vec      = issue ? enc_vec : '0;
        st_d.cause    = issue ? enc_cause : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_req_o   = st_q.req;
    assign take_vec_o   = st_q.vec;
    assign take_cause_o = st_q.cause;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int unsigned FP_MODE_W = 2,
    parameter int unsigned VEC_W     = 12,
    parameter int unsigned CAUSE_W   = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ext_en_i,
    input logic [FP_MODE_W-1:0] fp_mode_i,
    input logic                 fp_sum_i,
    input logic                 take_ack_i,
    input logic                 take_req_o,
    input logic [VEC_W-1:0]     take_vec_o,
    input logic [CAUSE_W-1:0]   take_cause_o
);
    logic outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else begin
            outst_q <= (outst_q || take_req_o) && !take_ack_i;
        end
    end

    p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o |=> !take_req_o);

    p_wait_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o |-> !outst_q);

    p_fp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req_o && take_vec_o == VEC_W'(VEC_FPE_OFS))
            |-> ($past((|fp_mode_i) && fp_sum_i) && take_cause_o != '0));

    p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req_o && take_vec_o != VEC_W'(VEC_FPE_OFS)) |-> $past(ext_en_i));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_req_o |-> (take_vec_o == '0 && take_cause_o == '0));
endmodule

bind irq_arbiter irq_arbiter_chk #(
    .FP_MODE_W (FP_MODE_W),
    .VEC_W     (VEC_W),
    .CAUSE_W   (CAUSE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_en_i     (ext_en_i),
    .fp_mode_i    (fp_mode_i),
    .fp_sum_i     (fp_sum_i),
    .take_ack_i   (take_ack_i),
    .take_req_o   (take_req_o),
    .take_vec_o   (take_vec_o),
    .take_cause_o (take_cause_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    localparam int unsigned FMW = 2;
    localparam int unsigned VW  = 12;
    localparam int unsigned CW  = 32;
    localparam logic [CW-1:0] FPE_CAUSE = 32'h0012_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ext_irq = 1'b0;
    logic           dec_pulse = 1'b0;
    logic           ext_en = 1'b0;
    logic [FMW-1:0] fp_mode = '0;
    logic           fp_sum = 1'b0;
    logic           ack = 1'b0;
    logic           req;
    logic [VW-1:0]  vec;
    logic [CW-1:0]  cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit m_ext, m_dec, m_busy, m_req;
    logic [VW-1:0] m_vec;
    logic [CW-1:0] m_cause;

    always #2 clk = ~clk;

    irq_arbiter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_irq_i    (ext_irq),
        .dec_pulse_i  (dec_pulse),
        .ext_en_i     (ext_en),
        .fp_mode_i    (fp_mode),
        .fp_sum_i     (fp_sum),
        .take_ack_i   (ack),
        .take_req_o   (req),
        .take_vec_o   (vec),
        .take_cause_o (cause)
    );

    function automatic logic [VW-1:0] exp_vec(bit fp, bit eh, bit dh);
        if (fp) return VW'(12'h700);
        if (eh) return VW'(12'h500);
        if (dh) return VW'(12'h900);
        return '0;
    endfunction

    task automatic model_edge();
        bit fp, eh, dh, iss;
        fp = (|fp_mode) && fp_sum;
        eh = ext_en && m_ext;
        dh = ext_en && m_dec && !m_ext;
        iss = !m_busy && (fp || eh || dh);
        m_req   = iss;
        m_vec   = iss ? exp_vec(fp, eh, dh) : '0;
        m_cause = (iss && fp) ? FPE_CAUSE : '0;
        m_dec   = dec_pulse || (m_dec && !(iss && !fp && !eh));
        m_ext   = ext_irq;
        m_busy  = m_busy ? !ack : iss;
    endtask

    task automatic model_reset();
        m_ext = 0; m_dec = 0; m_busy = 0; m_req = 0; m_vec = '0; m_cause = '0;
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic e_req, logic [VW-1:0] e_vec,
                         logic [CW-1:0] e_cause);
        n_chk++;
        if (req !== e_req || vec !== e_vec || cause !== e_cause) begin
            n_bad++;
            $display("FAIL %s: req/vec/cause got %0b/%h/%h expected %0b/%h/%h",
                     tag, req, vec, cause, e_req, e_vec, e_cause);
        end
    endtask

    task automatic idle(string tag);
        check(tag, 1'b0, '0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1207));
        do_reset();

        // R1 reset state
        ext_en = 1; step(); idle("R1 after reset");

        // R2 summary bit alone with no mode bit raises nothing
        ext_en = 0; fp_sum = 1; step(); idle("R2 no mode bit");
        fp_mode = 2'b01; step(); check("R2 fp request, enable low", 1, 12'h700, FPE_CAUSE);
        fp_mode = 0; fp_sum = 0; ack = 1; step(); idle("R8 ack cycle");
        ack = 0; step(); idle("R2 fp gone");

        // R3 masked external, then R7 delivery on enable
        ext_irq = 1; step(); idle("R3 masked 1");
        step(); idle("R3 masked 2");
        step(); idle("R3 masked 3");
        ext_en = 1; step(); check("R7 late enable", 1, 12'h500, 0);
        ack = 1; step(); idle("R8 ack");
        ack = 0; step(); check("R5 level held redelivery", 1, 12'h500, 0);
        ext_en = 0; ack = 1; step(); idle("R3 disabled");
        ack = 0; ext_irq = 0; step(); idle("R5 line low");
        ext_en = 1; step(); idle("R5 cleared by deassert");
        step(); idle("R5 cleared by deassert 2");

        // R4 ext over dec, then R6 dec once
        ext_en = 0; dec_pulse = 1; step(); dec_pulse = 0;
        ext_irq = 1; step(); idle("R3 both masked");
        ext_en = 1; step(); check("R4 ext first", 1, 12'h500, 0);
        ack = 1; ext_irq = 0; ext_en = 0; step(); idle("R8 ack");
        ack = 0; step(); idle("R3 dec masked");
        ext_en = 1; step(); check("R6 dec delivered", 1, 12'h900, 0);
        ack = 1; step(); idle("R8 ack");
        ack = 0; step(); idle("R6 dec once");
        step(); idle("R6 dec once 2");

        // R9 pulse coincident with the clear
        dec_pulse = 1; step(); idle("R9 pend set");
        step(); check("R9 first dec", 1, 12'h900, 0);
        dec_pulse = 0; ack = 1; step(); idle("R8 ack");
        ack = 0; step(); check("R9 second dec", 1, 12'h900, 0);
        ack = 1; step(); idle("R8 ack");
        ack = 0; step(); idle("R9 no third");

        // R8 hold off until ack; ack while idle ignored
        ack = 1; step(); idle("R8 idle ack");
        ack = 0;
        ext_irq = 1; step(); idle("R8 pend");
        step(); check("R8 request", 1, 12'h500, 0);
        for (int i = 0; i < 5; i++) begin
            step(); idle("R8 waiting for ack");
        end
        ack = 1; step(); idle("R8 ack");
        ack = 0; step(); check("R8 after ack", 1, 12'h500, 0);

        // R2 fp wins over pending external with enable set
        ack = 1; step(); ack = 0;
        fp_mode = 2'b10; fp_sum = 1; step(); check("R2 fp over ext", 1, 12'h700, FPE_CAUSE);
        fp_mode = 0; fp_sum = 0; ext_irq = 0; ext_en = 0; ack = 1; step();
        ack = 0; step(); idle("R10 quiet");

        // R1 reset drops a pending decrementer
        dec_pulse = 1; step(); dec_pulse = 0; step();
        do_reset();
        ext_en = 1; step(); idle("R1 dec flag cleared");
        step(); idle("R1 dec flag cleared 2");

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            ext_irq   = ($urandom % 8) < 3 ? ~ext_irq : ext_irq;
            dec_pulse = ($urandom % 10) == 0;
            ext_en    = ($urandom % 4) != 0;
            fp_mode   = FMW'($urandom % 4);
            fp_sum    = ($urandom % 12) == 0;
            ack       = ($urandom % 3) == 0;
            step();
            check("R2 R4 R6 R8 R10 random", m_req, m_vec, m_cause);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule